// File: doc/BRIEF.md
# Network Analyser Point Sequencer

This block runs the measurement program for each frequency point of a two-port vector network analyser sweep. A controller stores precomputed synthesizer register words in a show-ahead FIFO. For each point the block reads a header word, then sends every register word serially to the stimulus synthesizer and then to the first local-oscillator synthesizer. A latch-enable pulse follows each word. The block then sets the port switch for the forward direction and waits a programmable settling time. Next it starts the sampling/DFT engine and waits for that engine to finish. It repeats the switch, settle and acquire steps for the reverse direction and then reports the point as complete. The next point follows until the programmed number of points has been measured.

Serial traffic to the synthesizers and acquisition never overlap, because any new register word changes a synthesizer output at once. When the FIFO holds no word at the moment one is needed, the sequencer waits. It never reuses an old word. An abort request returns the block to idle, but a register word already being shifted is always completed and latched first.

States and transitions: `S_IDLE` goes to `S_HDR` on a start. `S_HDR` goes to `S_LOAD` when a header arrives that has words, or to `S_FWD_SW` when it has none. `S_LOAD` goes to `S_SHIFT` when a word is popped. `S_SHIFT` goes to `S_LATCH` when the shifter finishes. `S_LATCH` goes back to `S_LOAD` while words remain, and otherwise to `S_FWD_SW`. The forward steps run `S_FWD_SW`, then `S_FWD_SETTLE`, then `S_FWD_GO`, then `S_FWD_WAIT`. The reverse steps run `S_REV_SW`, then `S_REV_SETTLE`, then `S_REV_GO`, then `S_REV_WAIT`. After that comes `S_POINT_DONE`, which goes to `S_HDR`, or to `S_IDLE` after the last point. An abort sends every state except `S_SHIFT` to `S_IDLE`. From `S_SHIFT` an abort is held pending, and `S_LATCH` then exits to `S_IDLE`.

Top module: `sweep_point_seq`

## Requirements
- R1: While reset is held and just after it, busy, fifo_rd, spi_sclk, src_le, lo_le, sw_port2, acq_start and point_done are all 0.
- R2: A start pulse while idle with a nonzero sweep_len begins a sweep, and busy rises in the next cycle. A start with sweep_len equal to 0, or a start while busy, is ignored: no FIFO word is popped and no extra point is measured.
- R3: Each point begins by popping one header word. Its bits [3:0] give the number of stimulus-synthesizer words and its bits [7:4] the number of local-oscillator words. All stimulus words are sent first, then all local-oscillator words, each popped by one fifo_rd pulse in FIFO order.
- R4: Each register word is 32 bits, sent MSB first on spi_mosi and valid at the rising edge of spi_sclk, which idles low. After exactly 32 rising edges, one single-cycle pulse appears on src_le for a stimulus word or on lo_le for a local-oscillator word, with spi_sclk low.
- R5: While the FIFO is empty at a point where a header or word is needed, the block stays busy, pops nothing and drives no spi_sclk edge.
- R6: After the last word of a point (or after the header, if it has no words), sw_port2 is 0 and acq_start pulses with acq_dir 0 exactly K+2 cycles after the cycle of that last latch or pop. K is settle_cycles (captured at start) when it is nonzero and 1 when it is zero.
- R7: After acq_done is seen for the forward pass, sw_port2 is 1 and acq_start pulses with acq_dir 1 exactly K+2 cycles after the acq_done cycle.
- R8: From an acq_start pulse until the matching acq_done, spi_sclk, src_le and lo_le stay low.
- R9: point_done pulses for one cycle, the cycle after the reverse acq_done, with point_idx counting 0, 1, 2 and so on within the sweep. After the point numbered sweep_len-1, busy is low in the following cycle.
- R10: An abort raised while a word is being shifted lets that word finish. Its latch pulse appears two cycles after the abort cycle, and busy is low one cycle later, with no later word popped. An abort in any other busy state makes busy low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (sampled when idle) |
| sweep_len | input | 16 | Number of points in the sweep |
| settle_cycles | input | 16 | Settling wait in clock cycles, 0 gives one cycle |
| abort | input | 1 | Return to idle (after any word in flight) |
| fifo_empty | input | 1 | Register-word FIFO has no word |
| fifo_data | input | 32 | Word at the FIFO head (show-ahead) |
| fifo_rd | output | 1 | Pop the FIFO head |
| spi_sclk | output | 1 | Serial clock to both synthesizers |
| spi_mosi | output | 1 | Serial data, MSB first |
| src_le | output | 1 | Latch pulse for the stimulus synthesizer |
| lo_le | output | 1 | Latch pulse for the local-oscillator synthesizer |
| sw_port2 | output | 1 | Port switch: 0 drives port 1, 1 drives port 2 |
| acq_start | output | 1 | Start one acquisition |
| acq_dir | output | 1 | Direction of the acquisition: 0 forward, 1 reverse |
| acq_done | input | 1 | Acquisition finished |
| busy | output | 1 | Sweep in progress |
| point_done | output | 1 | Point completed strobe |
| point_idx | output | 16 | Index of the point being or just measured |

## Verification
The coincidence that matters most is an abort in the same cycle as the last serial clock edge of a word. In that cycle the shifter is finishing and the state machine must both remember the abort and still let the latch happen. The bench watches the serial clock, and in the cycle where the 32nd rising edge has just appeared it raises abort for one cycle. It then expects the latch pulse exactly two cycles later and busy low one cycle after that. It also checks that no further serial clock edge appears and that the second queued word is still in the FIFO.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR,
        S_LOAD,
        S_SHIFT,
        S_LATCH,
        S_FWD_SW,
        S_FWD_SETTLE,
        S_FWD_GO,
        S_FWD_WAIT,
        S_REV_SW,
        S_REV_SETTLE,
        S_REV_GO,
        S_REV_WAIT,
        S_POINT_DONE
    } seq_state_e;

endpackage

// File: rtl/swseq_spi_tx.sv
module swseq_spi_tx #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              done
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [BIT_W-1:0]  bits_left;
    logic              phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            phase     <= 1'b0;
            active    <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shreg     <= word;
                bits_left <= BIT_W'(WORD_W - 1);
                phase     <= 1'b0;
                active    <= 1'b1;
            end else if (active) begin
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (bits_left == '0) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        shreg     <= {shreg[WORD_W-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                    end
                end
            end
        end
    end

    assign sclk = active & phase;
    assign mosi = active & shreg[WORD_W-1];

    // R4: a new word is only handed over once the previous one is finished
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

endmodule

// File: rtl/swseq_settle_tmr.sv
module swseq_settle_tmr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             run,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? ONE : len;
        end else if (run && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

    // R6: the wait is never entered without a loaded count
    p_run_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt != '0);

endmodule

// File: rtl/sweep_point_seq.sv
module sweep_point_seq
    import swseq_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 16,
    parameter int SETTLE_W = 16,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IDX_W-1:0]    sweep_len,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                abort,
    input  logic                fifo_empty,
    input  logic [WORD_W-1:0]   fifo_data,
    output logic                fifo_rd,
    output logic                spi_sclk,
    output logic                spi_mosi,
    output logic                src_le,
    output logic                lo_le,
    output logic                sw_port2,
    output logic                acq_start,
    output logic                acq_dir,
    input  logic                acq_done,
    output logic                busy,
    output logic                point_done,
    output logic [IDX_W-1:0]    point_idx
);
    localparam int HDR_W = 2 * CNT_W;

    seq_state_e          state, nxt;
    logic [CNT_W-1:0]    src_left, lo_left;
    logic                tgt_lo;
    logic                abort_pend;
    logic [IDX_W-1:0]    pt_idx, pts_total;
    logic [SETTLE_W-1:0] settle_len;

    logic spi_start, spi_active, spi_done;
    logic tmr_load, tmr_run, tmr_last;
    logic have_word, words_left, last_point, hdr_empty;

    assign have_word  = !fifo_empty && !abort;
    assign words_left = (src_left != '0) || (lo_left != '0);
    assign last_point = (pt_idx == pts_total - IDX_W'(1));
    assign hdr_empty  = (fifo_data[HDR_W-1:0] == '0);

    swseq_spi_tx #(.WORD_W(WORD_W)) u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (spi_start),
        .word   (fifo_data),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .active (spi_active),
        .done   (spi_done)
    );

    swseq_settle_tmr #(.CNT_W(SETTLE_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (settle_len),
        .run   (tmr_run),
        .last  (tmr_last)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (start && sweep_len != '0) nxt = S_HDR;
            S_HDR:        if (abort) nxt = S_IDLE;
                          else if (!fifo_empty) nxt = hdr_empty ? S_FWD_SW : S_LOAD;
            S_LOAD:       if (abort) nxt = S_IDLE;
                          else if (!fifo_empty) nxt = S_SHIFT;
            S_SHIFT:      if (spi_done) nxt = S_LATCH;
            S_LATCH:      if (abort || abort_pend) nxt = S_IDLE;
                          else nxt = words_left ? S_LOAD : S_FWD_SW;
            S_FWD_SW:     nxt = abort ? S_IDLE : S_FWD_SETTLE;
            S_FWD_SETTLE: if (abort) nxt = S_IDLE;
                          else if (tmr_last) nxt = S_FWD_GO;
            S_FWD_GO:     nxt = abort ? S_IDLE : S_FWD_WAIT;
            S_FWD_WAIT:   if (abort) nxt = S_IDLE;
                          else if (acq_done) nxt = S_REV_SW;
            S_REV_SW:     nxt = abort ? S_IDLE : S_REV_SETTLE;
            S_REV_SETTLE: if (abort) nxt = S_IDLE;
                          else if (tmr_last) nxt = S_REV_GO;
            S_REV_GO:     nxt = abort ? S_IDLE : S_REV_WAIT;
            S_REV_WAIT:   if (abort) nxt = S_IDLE;
                          else if (acq_done) nxt = S_POINT_DONE;
            S_POINT_DONE: nxt = (abort || last_point) ? S_IDLE : S_HDR;
            default:      nxt = S_IDLE;
        endcase
    end

    // state register and per-point bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            src_left   <= '0;
            lo_left    <= '0;
            tgt_lo     <= 1'b0;
            abort_pend <= 1'b0;
            pt_idx     <= '0;
            pts_total  <= '0;
            settle_len <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: begin
                    abort_pend <= 1'b0;
                    if (start && sweep_len != '0) begin
                        pt_idx     <= '0;
                        pts_total  <= sweep_len;
                        settle_len <= settle_cycles;
                    end
                end
                S_HDR: if (have_word) begin
                    src_left <= fifo_data[CNT_W-1:0];
                    lo_left  <= fifo_data[HDR_W-1:CNT_W];
                end
                S_LOAD: if (have_word) begin
                    if (src_left != '0) begin
                        src_left <= src_left - 1'b1;
                        tgt_lo   <= 1'b0;
                    end else begin
                        lo_left  <= lo_left - 1'b1;
                        tgt_lo   <= 1'b1;
                    end
                end
                S_SHIFT: if (abort) abort_pend <= 1'b1;
                S_POINT_DONE: if (!last_point) pt_idx <= pt_idx + IDX_W'(1);
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        fifo_rd    = ((state == S_HDR) || (state == S_LOAD)) && have_word;
        spi_start  = (state == S_LOAD) && have_word;
        src_le     = (state == S_LATCH) && !tgt_lo;
        lo_le      = (state == S_LATCH) && tgt_lo;
        tmr_load   = (state == S_FWD_SW) || (state == S_REV_SW);
        tmr_run    = (state == S_FWD_SETTLE) || (state == S_REV_SETTLE);
        sw_port2   = (state == S_REV_SW) || (state == S_REV_SETTLE) ||
                     (state == S_REV_GO) || (state == S_REV_WAIT);
        acq_start  = (state == S_FWD_GO) || (state == S_REV_GO);
        acq_dir    = sw_port2;
        busy       = (state != S_IDLE);
        point_done = (state == S_POINT_DONE);
        point_idx  = pt_idx;
    end

    // R2: an accepted start makes the block busy at once
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sweep_len != '0) |=> busy);

    // R8: the shifter is quiet through settling and acquisition
    p_no_spi_in_acq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_FWD_SETTLE, S_FWD_GO, S_FWD_WAIT,
                       S_REV_SW, S_REV_SETTLE, S_REV_GO, S_REV_WAIT}) |-> !spi_active);

    // R4: a latch pulse only follows a finished word
    p_le_after_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_le || lo_le) |-> $past(spi_done));

    // R5: no word shifts out of an empty FIFO
    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && fifo_empty) |=> !spi_active);

endmodule

// File: tb/tb_sweep_point_seq.sv
`timescale 1ns/1ps
module tb_sweep_point_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sweep_len = '0;
    logic [15:0] settle_cycles = '0;
    logic        abort = 1'b0;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_rd, spi_sclk, spi_mosi, src_le, lo_le, sw_port2;
    logic        acq_start, acq_dir, busy, point_done;
    logic        acq_done = 1'b0;
    logic [15:0] point_idx;

    always #2 clk = ~clk;

    sweep_point_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sweep_len(sweep_len),
        .settle_cycles(settle_cycles), .abort(abort), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .src_le(src_le), .lo_le(lo_le), .sw_port2(sw_port2),
        .acq_start(acq_start), .acq_dir(acq_dir), .acq_done(acq_done),
        .busy(busy), .point_done(point_done), .point_idx(point_idx)
    );

    // settle[31:16] src words[15:12] lo words[11:8] acquisition latency[7:0]
    localparam logic [31:0] VEC [4] = '{
        {16'd0,    4'd1, 4'd1, 8'd1},
        {16'd1,    4'd2, 4'd0, 8'd4},
        {16'd5000, 4'd0, 4'd3, 8'd2},
        {16'd7,    4'd0, 4'd0, 8'd10}
    };

    // FIFO model
    logic [31:0] mem [0:255];
    int          tag [0:255];
    int          wp = 0, rp = 0;
    logic [31:0] last_pop_w = '0;
    int          last_pop_t = 0;
    assign fifo_empty = (rp == wp);
    assign fifo_data  = mem[rp];
    always @(posedge clk) if (fifo_rd) begin
        last_pop_w <= mem[rp];
        last_pop_t <= tag[rp];
        rp <= rp + 1;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] cap = '0;
    int          nbits = 0;
    always @(posedge spi_sclk) begin
        cap   = {cap[30:0], spi_mosi};
        nbits = nbits + 1;
    end

    // shared settings read by the monitor
    int cur_k = 1, cur_lat = 1;

    // monitor and acquisition responder
    int m_chk = 0, m_fail = 0;
    int m_nle = 0, m_nacq = 0, m_npd = 0, m_last_pd = 0;
    int bit_mark = 0, last_evt = 0, done_cyc = 0, pend_cnt = 0, m_idx = 0;
    bit acq_pend = 0, prev_busy = 0, m_dir = 0;

    task automatic chk_m(input bit ok, input string req, input longint act, input longint exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin m_idx = 0; m_dir = 0; end
            prev_busy = busy;
            if (acq_pend && (spi_sclk || src_le || lo_le))
                chk_m(0, "R8 serial activity during acquisition", 1, 0);
            if (src_le || lo_le) begin
                chk_m(nbits - bit_mark == 32, "R4 bit count", nbits - bit_mark, 32);
                chk_m(cap == last_pop_w, "R4 word value", cap, last_pop_w);
                chk_m(lo_le == (last_pop_t == 2), "R3 word target", lo_le, last_pop_t == 2);
                chk_m(!spi_sclk && !(src_le && lo_le), "R4 latch form", spi_sclk, 0);
                bit_mark = nbits;
                m_nle++;
            end
            if (fifo_rd || src_le || lo_le) last_evt = cyc;
            if (acq_done) acq_done = 1'b0;
            if (acq_start) begin
                chk_m(cyc - last_evt == cur_k + 2, m_dir ? "R7 reverse settle gap" : "R6 forward settle gap",
                      cyc - last_evt, cur_k + 2);
                chk_m(acq_dir == m_dir && sw_port2 == m_dir, m_dir ? "R7 direction" : "R6 direction",
                      {acq_dir, sw_port2}, {m_dir, m_dir});
                m_dir = !m_dir;
                m_nacq++;
                acq_pend = 1;
                pend_cnt = cur_lat;
            end else if (acq_pend) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    acq_done = 1'b1;
                    done_cyc = cyc;
                    last_evt = cyc;
                    acq_pend = 0;
                end
            end
            if (point_done) begin
                chk_m(cyc == done_cyc + 1, "R9 point_done timing", cyc - done_cyc, 1);
                chk_m(point_idx == 16'(m_idx), "R9 point index", point_idx, m_idx);
                m_idx++;
                m_npd++;
                m_last_pd = cyc;
            end
        end
    end

    // stimulus side
    int i_chk = 0, i_fail = 0;
    bit wd_hit = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        i_chk++;
        if (!ok) begin
            i_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input logic [31:0] w, input int t);
        mem[wp] = w;
        tag[wp] = t;
        wp = wp + 1;
    endtask

    task automatic push_point(input int ns, input int nl, input int seed);
        push({24'h0, 4'(nl), 4'(ns)}, 0);
        for (int i = 0; i < ns + nl; i++)
            push(32'h80000001 ^ (32'(seed) * 32'h01000193) ^ (32'(i + 1) * 32'h9E3779B9),
                 (i < ns) ? 1 : 2);
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        sweep_len = 16'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 i_chk + m_chk + int'(wd_hit), i_fail + m_fail + int'(wd_hit));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({busy, fifo_rd, spi_sclk, src_le, lo_le, sw_port2, acq_start, point_done} == '0,
            "R1 outputs in reset", {busy, fifo_rd, spi_sclk, src_le, lo_le, sw_port2, acq_start, point_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, fifo_rd, spi_sclk, src_le, lo_le, sw_port2, acq_start, point_done} == '0,
            "R1 outputs after reset", {busy, fifo_rd, spi_sclk, src_le, lo_le, sw_port2, acq_start, point_done}, 0);

        // R2: zero-length sweep is ignored
        push_point(1, 1, 99);
        pulse_start(0);
        repeat (3) @(negedge clk);
        chk(!busy && rp == 0, "R2 zero sweep_len ignored", {busy, rp[7:0]}, 0);
        wp = rp;

        // vector table: two-point sweeps
        for (int v = 0; v < 4; v++) begin
            int ns, nl, le0, acq0, pd0;
            ns = int'(VEC[v][15:12]);
            nl = int'(VEC[v][11:8]);
            cur_k = (VEC[v][31:16] == 0) ? 1 : int'(VEC[v][31:16]);
            cur_lat = int'(VEC[v][7:0]);
            settle_cycles = VEC[v][31:16];
            le0 = m_nle; acq0 = m_nacq; pd0 = m_npd;
            push_point(ns, nl, 2 * v);
            push_point(ns, nl, 2 * v + 1);
            pulse_start(2);
            chk(busy, "R2 busy after start", busy, 1);
            wait_idle();
            chk(m_nle - le0 == 2 * (ns + nl), "R3 words latched per sweep", m_nle - le0, 2 * (ns + nl));
            chk(m_nacq - acq0 == 4, "R6 R7 acquisitions per sweep", m_nacq - acq0, 4);
            chk(m_npd - pd0 == 2, "R9 points per sweep", m_npd - pd0, 2);
            chk(cyc == m_last_pd + 1, "R9 busy drops after last point", cyc - m_last_pd, 1);
            chk(rp == wp, "R3 all words consumed", wp - rp, 0);
        end

        // R5 stall on empty FIFO; R2 start while busy ignored
        begin
            int b0, r0, pd0;
            cur_k = 3; cur_lat = 2; settle_cycles = 16'd3;
            b0 = nbits; r0 = rp; pd0 = m_npd;
            pulse_start(1);
            repeat (30) @(negedge clk);
            chk(busy && nbits == b0 && rp == r0, "R5 stall while FIFO empty",
                {busy, 8'(nbits - b0), 8'(rp - r0)}, {1'b1, 16'h0});
            pulse_start(3);
            push_point(1, 1, 77);
            wait_idle();
            chk(m_npd - pd0 == 1, "R2 start while busy ignored", m_npd - pd0, 1);
            chk(nbits - b0 == 64, "R5 words sent after refill", nbits - b0, 64);
        end

        // R10: abort coincident with the last serial edge of a word
        begin
            int b0, le0;
            b0 = nbits; le0 = m_nle;
            push_point(2, 0, 55);
            pulse_start(1);
            do @(negedge clk); while (nbits != b0 + 32);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            @(negedge clk);
            chk(src_le, "R10 word latched after abort", src_le, 1);
            @(negedge clk);
            chk(!busy, "R10 idle after aborted word", busy, 0);
            repeat (5) @(negedge clk);
            chk(nbits - b0 == 32 && m_nle - le0 == 1, "R10 no further word",
                nbits - b0, 32);
            chk(wp - rp == 1, "R10 second word left in FIFO", wp - rp, 1);
            wp = rp;
        end

        // R10: abort during settling
        begin
            int a0, r0;
            settle_cycles = 16'd5000; cur_k = 5000;
            a0 = m_nacq; r0 = rp;
            push_point(0, 0, 66);
            pulse_start(1);
            do @(negedge clk); while (rp == r0);
            repeat (10) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            chk(!busy, "R10 abort in settle idles next cycle", busy, 1'b0);
            chk(m_nacq == a0 && !sw_port2, "R10 no acquisition after abort", m_nacq - a0, 0);
        end

        repeat (4) @(negedge clk);
        report();
        $finish;
    end

endmodule